// File: doc/BRIEF.md
# Hashed page table lookup engine

This block translates a 32-bit effective address by searching a hashed page table kept in an on-chip entry store. The address is cut into a segment identifier (the top four bits, taken one-to-one as the virtual segment ID) and a 16-bit page index. A primary hash selects one group of eight entries. If none of them matches, the complement of that hash selects a second group. The table size masks the group number. The table base is OR-ed into the byte address of the matching entry.

A lookup is started with a valid/ready request handshake. The engine reads one entry per clock: the eight slots of the primary group first, then the eight slots of the secondary group. It stops at the first entry that matches. It then holds a response until that response is consumed. The response carries hit or miss, the entry number within the table, the entry's byte address, its physical page number, its WIMG attributes and its protection bits. The table geometry is loaded through a small configuration port that refuses illegal settings. Entries are loaded through a write port.

Top module: `hpt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `cfg_ok` is 0 and `cfg_reject` is 0.
- R2: A configuration write is legal when `cfg_log2` is between 16 and 25 inclusive and the low `cfg_log2` bits of `cfg_base` are all zero. A legal write installs the geometry and sets `cfg_ok` at the next edge. An illegal write pulses `cfg_reject` for one cycle, and the previously installed geometry and `cfg_ok` are unchanged.
- R3: A request accepted while `cfg_ok` is 0 is answered with a miss, with `resp_valid` set on the accepting edge itself, and no entry is read.
- R4: The request VSID is `req_ea[31:28]` zero-extended to 24 bits. The page index is `req_ea[27:12]` and the abbreviated page index is `req_ea[27:22]`. The primary hash is the low 19 bits of (VSID XOR page index). The secondary hash is the bitwise complement of the primary hash, taken to 19 bits.
- R5: The primary group number is the primary hash AND (2^(cfg_log2-6) - 1), and its slots 0..7 are scanned first. When the match is found at scan position k (0..15, with the secondary slots at 8..15), `resp_valid` rises k+2 edges after the accepting edge.
- R6: The secondary group, built the same way from the secondary hash, is scanned only after all eight primary slots have failed. An entry matches there only if its hash-select bit is 1, while in the primary group the bit must be 0.
- R7: An entry matches only when its valid bit is set, its 24-bit VSID equals the request VSID and its 6-bit abbreviated page index equals the request's.
- R8: When several entries match, the first in scan order is returned.
- R9: A lookup that finds no match reads exactly 16 entries, and reports a miss 17 edges after the accepting edge. A miss carries an index, address and translation fields of zero.
- R10: On a hit, `resp_idx` = {group number, slot[2:0]} (22 bits), and `resp_addr` = `cfg_base` OR (`resp_idx` << 3).
- R11: `req_ready` is 1 only when no lookup is in progress and no response is pending. A response and all its fields stay stable while `resp_valid` is 1 and `resp_ready` is 0.
- R12: An entry is written with `wr_en`, and it goes to store slot `wr_idx`. The store slot used for table entry n is the low 10 bits of n, so larger tables alias onto the store. `wr_data` holds valid at bit 57, the VSID at bits 56:33, hash-select at bit 32, the abbreviated page index at bits 31:26, the physical page number at bits 25:6, WIMG at bits 5:2 and protection at bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_base | input | 32 | Table base byte address |
| cfg_log2 | input | 5 | Base-two log of the table size in bytes |
| cfg_ok | output | 1 | A legal geometry is installed |
| cfg_reject | output | 1 | One-cycle pulse after an illegal configuration write |
| wr_en | input | 1 | Entry store write strobe |
| wr_idx | input | 10 | Entry store slot |
| wr_data | input | 58 | Entry contents |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_ea | input | 32 | Effective address to translate |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumed |
| resp_hit | output | 1 | A matching entry was found |
| resp_idx | output | 22 | Entry number within the table |
| resp_addr | output | 32 | Byte address of the matching entry |
| resp_rpn | output | 20 | Physical page number |
| resp_wimg | output | 4 | WIMG attributes |
| resp_pp | output | 2 | Protection bits |

## Verification
The assertions assume that configuration writes and entry writes happen only while the engine is idle with no response pending. They also assume that `req_ea` is steady on the accepting edge. Geometry and table contents that change during a scan would make the reported index and latency meaningless. The stimulus keeps to this. It installs each geometry and plants all sixteen candidate slots before it issues a lookup. It then waits for the response to be consumed before touching either port again. The random entries are built around the request, so that matches, invalid look-alikes, wrong-VSID and wrong-API entries, and hash-select decoys all land in the two groups that are actually scanned.

// File: rtl/hpt_pkg.sv
// Shared geometry constants and the entry layout of the hashed page table engine.
// Assumes 4 KiB pages, 256 MiB segments and eight 8-byte entries per group.
package hpt_pkg;
    localparam int EA_W         = 32;
    localparam int PG_LOG2      = 12;
    localparam int SEG_LOG2     = 28;
    localparam int PI_W         = SEG_LOG2 - PG_LOG2;
    localparam int SID_W        = EA_W - SEG_LOG2;
    localparam int VSID_W       = 24;
    localparam int HASH_W       = 19;
    localparam int ENT_LOG2     = 3;
    localparam int GRP_LOG2     = 6;
    localparam int SLOT_W       = GRP_LOG2 - ENT_LOG2;
    localparam int SLOTS        = 1 << SLOT_W;
    localparam int SCAN_W       = SLOT_W + 1;
    localparam int API_W        = 6;
    localparam int RPN_W        = 20;
    localparam int WIMG_W       = 4;
    localparam int PP_W         = 2;
    localparam int LOG2_W       = 5;
    localparam int MIN_TBL_LOG2 = 16;
    localparam int MAX_TBL_LOG2 = HASH_W + GRP_LOG2;
    localparam int IDX_W        = HASH_W + SLOT_W;

    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              hsel;
        logic [API_W-1:0]  api;
        logic [RPN_W-1:0]  rpn;
        logic [WIMG_W-1:0] wimg;
        logic [PP_W-1:0]   pp;
    } hpt_entry_t;

    localparam int ENTRY_W = $bits(hpt_entry_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } scan_state_t;
endpackage

// File: rtl/hpt_addr_split.sv
// Splits the page-number part of an effective address into the one-to-one
// segment ID, the abbreviated page index and the primary hash.
// Assumes the segment ID is the top address bits, zero-extended to a VSID.
module hpt_addr_split
    import hpt_pkg::*;
(
    input  logic [EA_W-PG_LOG2-1:0] page_num,
    output logic [VSID_W-1:0]       vsid,
    output logic [API_W-1:0]        api,
    output logic [HASH_W-1:0]       hash1
);
    logic [PI_W-1:0]   pindex;
    logic [VSID_W-1:0] pi_ext;
    logic [VSID_W-1:0] mix;

    // Cut the page number into the segment and page index fields.
    always_comb begin
        pindex = page_num[PI_W-1:0];
        vsid   = VSID_W'(page_num[EA_W-PG_LOG2-1:PI_W]);
        api    = pindex[PI_W-1:PI_W-API_W];
        pi_ext = VSID_W'(pindex);
        mix    = vsid ^ pi_ext;
        hash1  = mix[HASH_W-1:0];
    end
endmodule

// File: rtl/hpt_cfg.sv
// Holds the table base and size, checks new settings for legality and derives
// the group-number mask. Assumes writes arrive only while the engine is idle.
module hpt_cfg
    import hpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [EA_W-1:0]   cfg_base,
    input  logic [LOG2_W-1:0] cfg_log2,
    output logic              cfg_ok,
    output logic              cfg_reject,
    output logic [EA_W-1:0]   base_q,
    output logic [HASH_W-1:0] grp_mask
);
    logic [LOG2_W-1:0] log2_q;
    logic [EA_W-1:0]   align_mask;
    logic              size_ok;
    logic              legal;

    // Legality of the offered geometry: size range and base alignment.
    always_comb begin
        align_mask = ~({EA_W{1'b1}} << cfg_log2);
        size_ok    = (cfg_log2 >= LOG2_W'(MIN_TBL_LOG2)) && (cfg_log2 <= LOG2_W'(MAX_TBL_LOG2));
        legal      = size_ok && ((cfg_base & align_mask) == '0);
    end

    // Install legal geometry, pulse the reject flag otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            log2_q     <= '0;
            cfg_ok     <= 1'b0;
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= cfg_we && !legal;
            if (cfg_we && legal) begin
                base_q <= cfg_base;
                log2_q <= cfg_log2;
                cfg_ok <= 1'b1;
            end
        end
    end

    // Group mask keeps log2 - 6 low bits of the hash.
    always_comb begin
        grp_mask = {HASH_W{1'b1}} >> (LOG2_W'(MAX_TBL_LOG2) - log2_q);
    end
endmodule

// File: rtl/hpt_store.sv
// Single-port-read, single-port-write entry store with a registered read.
// Assumes no write to the slot being read in the same cycle.
module hpt_store
    import hpt_pkg::*;
#(
    parameter int STORE_IDX_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [STORE_IDX_W-1:0] wr_idx,
    input  hpt_entry_t             wr_entry,
    input  logic                   rd_en,
    input  logic [STORE_IDX_W-1:0] rd_idx,
    output hpt_entry_t             rd_entry
);
    localparam int DEPTH = 1 << STORE_IDX_W;

    hpt_entry_t mem [DEPTH];

    // Entry write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    // Registered read port, one entry per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_entry <= '0;
        end else if (rd_en) begin
            rd_entry <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/hpt_scan.sv
// Request handshake and sequential two-group scan. Issues one store read per
// clock (primary slots, then secondary), compares the returned entry one cycle
// later and stops at the first match. Assumes the geometry and the store are
// steady during a scan.
module hpt_scan
    import hpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic [HASH_W-1:0] grp_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  hpt_entry_t        rd_entry,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_hit,
    output logic [IDX_W-1:0]  resp_idx,
    output logic [RPN_W-1:0]  resp_rpn,
    output logic [WIMG_W-1:0] resp_wimg,
    output logic [PP_W-1:0]   resp_pp
);
    scan_state_t       state_q;
    logic [VSID_W-1:0] in_vsid;
    logic [API_W-1:0]  in_api;
    logic [HASH_W-1:0] in_hash;
    logic [VSID_W-1:0] vsid_q;
    logic [API_W-1:0]  api_q;
    logic [HASH_W-1:0] hash_q;
    logic [SCAN_W-1:0] cnt_q;
    logic              issue_end_q;
    logic              cmp_vld_q;
    logic [SCAN_W-1:0] cmp_cnt_q;
    logic [HASH_W-1:0] issue_grp;
    logic [HASH_W-1:0] cmp_grp;
    logic              match;
    logic              last_cmp;

    hpt_addr_split u_split (
        .page_num (req_ea[EA_W-1:PG_LOG2]),
        .vsid     (in_vsid),
        .api      (in_api),
        .hash1    (in_hash)
    );

    // Group selection for the slot being read and the slot being compared.
    always_comb begin
        issue_grp = (cnt_q[SLOT_W] ? ~hash_q : hash_q) & grp_mask;
        cmp_grp   = (cmp_cnt_q[SLOT_W] ? ~hash_q : hash_q) & grp_mask;
        rd_en     = (state_q == ST_SCAN) && !issue_end_q;
        rd_idx    = {issue_grp, cnt_q[SLOT_W-1:0]};
        req_ready = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
    end

    // Entry comparison; hash-select must equal the secondary flag of the slot.
    always_comb begin
        match = cmp_vld_q && rd_entry.valid && (rd_entry.vsid == vsid_q) &&
                (rd_entry.api == api_q) && (rd_entry.hsel == cmp_cnt_q[SLOT_W]);
        last_cmp = cmp_vld_q && (cmp_cnt_q == {SCAN_W{1'b1}});
    end

    // Lookup sequencer: accept, scan, respond, wait for consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            vsid_q      <= '0;
            api_q       <= '0;
            hash_q      <= '0;
            cnt_q       <= '0;
            issue_end_q <= 1'b0;
            cmp_vld_q   <= 1'b0;
            cmp_cnt_q   <= '0;
            resp_hit    <= 1'b0;
            resp_idx    <= '0;
            resp_rpn    <= '0;
            resp_wimg   <= '0;
            resp_pp     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vsid_q      <= in_vsid;
                        api_q       <= in_api;
                        hash_q      <= in_hash;
                        cnt_q       <= '0;
                        issue_end_q <= 1'b0;
                        cmp_vld_q   <= 1'b0;
                        resp_hit    <= 1'b0;
                        resp_idx    <= '0;
                        resp_rpn    <= '0;
                        resp_wimg   <= '0;
                        resp_pp     <= '0;
                        state_q     <= cfg_ok ? ST_SCAN : ST_RESP;
                    end
                end
                ST_SCAN: begin
                    cmp_vld_q <= rd_en;
                    cmp_cnt_q <= cnt_q;
                    if (rd_en) begin
                        if (cnt_q == {SCAN_W{1'b1}}) begin
                            issue_end_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    if (match) begin
                        state_q   <= ST_RESP;
                        resp_hit  <= 1'b1;
                        resp_idx  <= {cmp_grp, cmp_cnt_q[SLOT_W-1:0]};
                        resp_rpn  <= rd_entry.rpn;
                        resp_wimg <= rd_entry.wimg;
                        resp_pp   <= rd_entry.pp;
                    end else if (last_cmp) begin
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (resp_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpt_lookup.sv
// Top of the hashed page table lookup engine: configuration, entry store and
// scan sequencer. Assumes configuration and entry writes only while idle.
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int STORE_IDX_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [31:0]            cfg_base,
    input  logic [4:0]             cfg_log2,
    output logic                   cfg_ok,
    output logic                   cfg_reject,
    input  logic                   wr_en,
    input  logic [STORE_IDX_W-1:0] wr_idx,
    input  logic [57:0]            wr_data,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [31:0]            req_ea,
    output logic                   resp_valid,
    input  logic                   resp_ready,
    output logic                   resp_hit,
    output logic [21:0]            resp_idx,
    output logic [31:0]            resp_addr,
    output logic [19:0]            resp_rpn,
    output logic [3:0]             resp_wimg,
    output logic [1:0]             resp_pp
);
    logic [EA_W-1:0]   base_q;
    logic [HASH_W-1:0] grp_mask;
    logic              rd_en;
    logic [IDX_W-1:0]  rd_idx;
    hpt_entry_t        rd_entry;
    hpt_entry_t        wr_entry;

    hpt_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_base   (cfg_base),
        .cfg_log2   (cfg_log2),
        .cfg_ok     (cfg_ok),
        .cfg_reject (cfg_reject),
        .base_q     (base_q),
        .grp_mask   (grp_mask)
    );

    // Reinterpret the flat write word as an entry.
    always_comb wr_entry = hpt_entry_t'(wr_data);

    hpt_store #(.STORE_IDX_W(STORE_IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx[STORE_IDX_W-1:0]),
        .rd_entry (rd_entry)
    );

    hpt_scan u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ok     (cfg_ok),
        .grp_mask   (grp_mask),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_ea     (req_ea),
        .rd_en      (rd_en),
        .rd_idx     (rd_idx),
        .rd_entry   (rd_entry),
        .resp_valid (resp_valid),
        .resp_ready (resp_ready),
        .resp_hit   (resp_hit),
        .resp_idx   (resp_idx),
        .resp_rpn   (resp_rpn),
        .resp_wimg  (resp_wimg),
        .resp_pp    (resp_pp)
    );

    // Entry byte address: table base OR the entry offset.
    always_comb resp_addr = resp_hit ? (base_q | EA_W'({resp_idx, 3'b000})) : '0;
endmodule

// File: rtl/hpt_lookup_chk.sv
// Port-level protocol and timing checks for hpt_lookup, attached by bind.
// Assumes configuration writes happen only while idle.
module hpt_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_base,
    input logic [4:0]  cfg_log2,
    input logic        cfg_ok,
    input logic        cfg_reject,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_ready,
    input logic        resp_hit,
    input logic [21:0] resp_idx,
    input logic [31:0] resp_addr,
    input logic [19:0] resp_rpn
);
    logic       legal;
    logic [4:0] busy_cnt;

    // Expected legality of an offered geometry, from the port values.
    always_comb begin
        legal = (cfg_log2 >= 5'd16) && (cfg_log2 <= 5'd25) &&
                ((cfg_base & ~(32'hFFFF_FFFF << cfg_log2)) == 32'd0);
    end

    // Cycles spent with a lookup in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!req_ready && !resp_valid) begin
            busy_cnt <= busy_cnt + 5'd1;
        end else begin
            busy_cnt <= '0;
        end
    end

    p_cfg_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && legal |=> cfg_ok && !cfg_reject);
    p_cfg_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !legal |=> cfg_reject && $stable(cfg_ok));
    p_unconf_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !cfg_ok |=> resp_valid && !resp_hit);
    p_scan_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 5'd17);
    p_entry_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> resp_addr[5:3] == resp_idx[2:0]);
    p_busy_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    p_resp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) &&
        $stable(resp_idx) && $stable(resp_rpn) && $stable(resp_addr));
endmodule

bind hpt_lookup hpt_lookup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_base   (cfg_base),
    .cfg_log2   (cfg_log2),
    .cfg_ok     (cfg_ok),
    .cfg_reject (cfg_reject),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_hit   (resp_hit),
    .resp_idx   (resp_idx),
    .resp_addr  (resp_addr),
    .resp_rpn   (resp_rpn)
);

// File: tb/hpt_lookup_tb.sv
`timescale 1ns/1ps
module hpt_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_log2 = '0;
    logic        cfg_ok, cfg_reject;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_idx = '0;
    logic [57:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ea = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic        resp_hit;
    logic [21:0] resp_idx;
    logic [31:0] resp_addr;
    logic [19:0] resp_rpn;
    logic [3:0]  resp_wimg;
    logic [1:0]  resp_pp;

    always #2 clk = ~clk;

    hpt_lookup u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [57:0] model [1024];
    logic [31:0] cur_base;
    logic [4:0]  cur_log2;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Entry word per R12 layout.
    function automatic logic [57:0] mk(input bit v, input logic [23:0] vs, input bit h,
                                       input logic [5:0] a, input logic [19:0] r,
                                       input logic [3:0] w, input logic [1:0] p);
        return {v, vs, h, a, r, w, p};
    endfunction

    task automatic wr_ent(input logic [21:0] idx, input logic [57:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[9:0]; wr_data = d;
        model[idx[9:0]] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_cfg(input logic [31:0] b, input logic [4:0] l, input bit legal);
        bit ok_before;
        ok_before = cfg_ok;
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = b; cfg_log2 = l;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_reject == !legal, "R2", "cfg_reject", cfg_reject, !legal);
        chk(cfg_ok == (legal ? 1'b1 : ok_before), "R2", "cfg_ok", cfg_ok, legal ? 1 : ok_before);
        if (legal) begin cur_base = b; cur_log2 = l; end
    endtask

    // Issue one lookup, return the number of negedges until resp_valid.
    task automatic lookup(input logic [31:0] ea, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end while (!resp_valid && lat < 40);
    endtask

    // Reference search per R4..R10 over the bench copy of the store.
    task automatic expect_lookup(input logic [31:0] ea, output bit hit, output int pos,
                                 output logic [21:0] idx, output logic [57:0] ent,
                                 output int nmatch);
        logic [23:0] vs; logic [15:0] pi; logic [18:0] h1, gm, g;
        logic [57:0] e;
        vs = {20'd0, ea[31:28]}; pi = ea[27:12];
        h1 = 19'(vs ^ {8'd0, pi});
        gm = 19'((1 << (cur_log2 - 6)) - 1);
        hit = 0; pos = 0; idx = '0; ent = '0; nmatch = 0;
        for (int k = 0; k < 16; k++) begin
            g = ((k >= 8) ? ~h1 : h1) & gm;
            e = model[10'({g, 3'(k)})];
            if (e[57] && e[56:33] == vs && e[31:26] == pi[15:10] && e[32] == (k >= 8)) begin
                nmatch++;
                if (!hit) begin hit = 1; pos = k; idx = {g, 3'(k)}; ent = e; end
            end
        end
    endtask

    // Plant sixteen candidate entries around ea, mixing matches and decoys.
    task automatic plant(input logic [31:0] ea);
        logic [23:0] vs; logic [15:0] pi; logic [18:0] h1, gm, g;
        logic [57:0] e; int kind; bit hs;
        vs = {20'd0, ea[31:28]}; pi = ea[27:12];
        h1 = 19'(vs ^ {8'd0, pi});
        gm = 19'((1 << (cur_log2 - 6)) - 1);
        for (int k = 0; k < 16; k++) begin
            g = ((k >= 8) ? ~h1 : h1) & gm;
            hs = (k >= 8);
            kind = $urandom % 12;
            e = mk(1'b1, vs, hs, pi[15:10], 20'($urandom), 4'($urandom), 2'($urandom));
            case (kind)
                0: ;
                1, 2: e[57] = 1'b0;
                3, 4: e[56:33] = vs ^ (24'd1 << ($urandom % 24));
                5, 6: e[31:26] = pi[15:10] ^ (6'd1 << ($urandom % 6));
                7, 8, 9: e[32] = ~hs;
                default: e = {1'b1, 57'({$urandom, $urandom})};
            endcase
            wr_ent({g, 3'(k)}, e);
        end
    endtask

    task automatic run_check(input logic [31:0] ea);
        bit hit; int pos, lat, nm; logic [21:0] idx; logic [57:0] ent;
        string tag;
        expect_lookup(ea, hit, pos, idx, ent, nm);
        lookup(ea, lat);
        tag = !hit ? "R9" : (nm > 1 ? "R8" : (pos < 8 ? "R5" : "R6"));
        chk(resp_hit == hit, tag, "hit", resp_hit, hit);
        chk(lat == (hit ? pos + 3 : 18), tag, "latency", lat, hit ? pos + 3 : 18);
        chk(resp_idx == idx, (idx >= 22'd1024) ? "R12" : "R10", "index", resp_idx, idx);
        chk(resp_addr == (hit ? (cur_base | {7'd0, idx, 3'd0}) : 32'd0), "R10", "addr",
            resp_addr, hit ? (cur_base | {7'd0, idx, 3'd0}) : 0);
        chk({resp_rpn, resp_wimg, resp_pp} == (hit ? ent[25:0] : 26'd0), "R7", "fields",
            {resp_rpn, resp_wimg, resp_pp}, hit ? ent[25:0] : 0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int lat;
        logic [57:0] e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
        chk(cfg_ok == 1'b0, "R1", "cfg_ok", cfg_ok, 0);
        chk(cfg_reject == 1'b0, "R1", "cfg_reject", cfg_reject, 0);

        // R3 lookup without geometry
        lookup(32'h1234_5000, lat);
        chk(lat == 1, "R3", "latency", lat, 1);
        chk(resp_hit == 1'b0, "R3", "hit", resp_hit, 0);

        // R2 illegal then legal geometry
        do_cfg(32'h0000_0000, 5'd15, 0);
        do_cfg(32'h0000_0000, 5'd26, 0);
        do_cfg(32'h0001_0000, 5'd17, 0);
        do_cfg(32'h0010_0000, 5'd16, 1);
        do_cfg(32'h0000_8000, 5'd16, 0);
        chk(cfg_ok == 1'b1, "R2", "kept after reject", cfg_ok, 1);

        // R4 directed hash: ea 5ABCD000 -> hash1 0ABC8, groups 3C8 and 037
        for (int k = 0; k < 8; k++) wr_ent({19'h3C8, 3'(k)}, 58'd0);
        for (int k = 0; k < 8; k++) wr_ent({19'h037, 3'(k)}, 58'd0);
        wr_ent({19'h3C8, 3'd3}, mk(1, 24'd5, 0, 6'h2A, 20'hBEEF1, 4'h5, 2'h2));
        lookup(32'h5ABC_D000, lat);
        chk(resp_hit && resp_idx == 22'h1E43, "R4", "primary index", resp_idx, 22'h1E43);
        chk(resp_addr == 32'h0010_F218, "R10", "addr", resp_addr, 32'h0010_F218);
        chk(lat == 6, "R5", "latency slot 3", lat, 6);

        // R6 primary with hsel 1 ignored; secondary with hsel 0 ignored, then hsel 1 found
        wr_ent({19'h3C8, 3'd3}, mk(1, 24'd5, 1, 6'h2A, 20'h11111, 4'h1, 2'h1));
        wr_ent({19'h037, 3'd2}, mk(1, 24'd5, 0, 6'h2A, 20'h22222, 4'h2, 2'h2));
        lookup(32'h5ABC_D000, lat);
        chk(resp_hit == 1'b0, "R6", "wrong hash-select ignored", resp_hit, 0);
        chk(lat == 18, "R9", "miss latency", lat, 18);
        wr_ent({19'h037, 3'd6}, mk(1, 24'd5, 1, 6'h2A, 20'h33333, 4'h3, 2'h3));
        lookup(32'h5ABC_D000, lat);
        chk(resp_hit && resp_idx == {19'h037, 3'd6}, "R6", "secondary index", resp_idx, {19'h037, 3'd6});
        chk(resp_rpn == 20'h33333, "R6", "rpn", resp_rpn, 20'h33333);
        chk(lat == 17, "R6", "latency pos 14", lat, 17);

        // R11 response held while not consumed
        @(negedge clk);
        resp_ready = 1'b0;
        lookup(32'h5ABC_D000, lat);
        repeat (3) begin
            @(negedge clk);
            chk(resp_valid && !req_ready && resp_rpn == 20'h33333, "R11", "hold",
                {resp_valid, req_ready}, 2'b10);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        chk(!resp_valid && req_ready, "R11", "release", {resp_valid, req_ready}, 2'b01);

        // Random lookups under three geometries
        for (int c = 0; c < 3; c++) begin
            case (c)
                0: do_cfg(32'h0010_0000, 5'd16, 1);
                1: do_cfg(32'h0004_0000, 5'd18, 1);
                default: do_cfg(32'h0200_0000, 5'd25, 1);
            endcase
            for (int t = 0; t < 100; t++) begin
                logic [31:0] ea;
                ea = $urandom;
                plant(ea);
                run_check(ea);
            end
        end
        finish_up();
    end
endmodule